// File: doc/BRIEF.md
# Precision-Configurable SIMD Multiply-Accumulate Element

This block is a multiply-accumulate processing element for signed two's complement integer or fixed-point data. The element always receives two 64-bit packed operand vectors. A 2-bit mode decides how those vectors are cut into lanes: sixteen 4x4 products, four 8x8 products, one 16x16 product, or four mixed 16x4 products. Every product, in every mode, is assembled from one fixed array of sixteen 4x4 sub-multipliers. In that array only the top nibble of each operand carries a sign. A shared reduction tree weights and sums the sub-products for the active mode.

Products pass through one pipeline register and then reach a bank of per-lane accumulators, which wrap on overflow. A synchronous clear zeroes the bank, and the clear is also the only moment when a new mode is taken in. A typical sequence is: clear with the wanted mode, stream operand vectors under `valid`, read the packed sums, then clear again.

Top module: `simd_mac_pe`

## Requirements
- R1: Mode 2'b00 (4x4): lane k (0..15) multiplies `a_vec[4k+3:4k]` by `b_vec[4k+3:4k]` and accumulates into a 12-bit sum at `acc_out[12k+11:12k]`.
- R2: Mode 2'b01 (8x8): lane l (0..3) multiplies `a_vec[8l+7:8l]` by `b_vec[8l+7:8l]`. Its 20-bit sum is placed, sign-extended, at `acc_out[48l+47:48l]`.
- R3: Mode 2'b10 (16x16): `a_vec[15:0]` times `b_vec[15:0]` accumulates into a 36-bit sum, sign-extended into `acc_out[47:0]`. `acc_out[191:48]` stays zero.
- R4: Mode 2'b11 (16x4): lane l (0..3) multiplies `a_vec[16l+15:16l]` by `b_vec[4l+3:4l]`. Its 24-bit sum is placed, sign-extended, at `acc_out[48l+47:48l]`.
- R5: Every operand field is read as a signed two's complement number, so all products and sums are signed.
- R6: A vector presented with `valid` high at clock edge t is first visible in `acc_out` after edge t+1. Vectors on consecutive cycles are all accumulated.
- R7: With `valid` low, the accumulators hold their value whatever the operand inputs do.
- R8: With `clear` high at an edge, every accumulator bit becomes zero. A vector presented in the same cycle is dropped, and so is a vector still in the pipeline register.
- R9: `mode` is sampled only on edges where `clear` is high. A change of `mode` at any other time has no effect on the arithmetic.
- R10: Each lane sum wraps modulo 2^W, where W is the lane width for the mode (12, 20, 36 or 24).
- R11: A synchronous active-low reset zeroes all accumulators, empties the pipeline and selects mode 4x4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Lane partition, taken in on clear: 00 4x4, 01 8x8, 10 16x16, 11 16x4 |
| valid | input | 1 | Operand vectors are valid this cycle |
| clear | input | 1 | Synchronous clear of all accumulators; loads mode |
| a_vec | input | 64 | Packed first operands |
| b_vec | input | 64 | Packed second operands |
| acc_out | output | 192 | Packed per-lane accumulator values |

## Verification
The assertions check several rules on every cycle:
- a clear empties the bank;
- an idle cycle leaves it unchanged;
- the latched mode moves only on a clear;
- a valid input always reaches the pipeline stage;
- the 8x8 slots stay sign-extended, and the bits above the 16x16 slot stay zero.

Only the bench scenarios can show that the arithmetic is right. To do this, the bench compares against products computed arithmetically:
- every 4x4 operand pair;
- swept and extreme 8x8, 16x16 and 16x4 operands;
- wrap-around in the narrowest and widest lanes;
- the exact cycle a result appears;
- that a vector arriving with a clear, or caught in the pipeline by one, is lost.

// File: rtl/simd_mac_pkg.sv
// Package: shared mode encoding for the SIMD MAC element.
// Assumes: the two mode bits are decoded exactly as listed below.
package simd_mac_pkg;

    typedef enum logic [1:0] {
        MODE_4X4   = 2'b00,
        MODE_8X8   = 2'b01,
        MODE_16X16 = 2'b10,
        MODE_16X4  = 2'b11
    } mode_e;

endpackage

// File: rtl/simd_submul_array.sv
// Module: simd_submul_array
// Routes operand nibbles to N_SUB small signed multipliers.
// The nibble routing depends on the mode.
// A nibble is sign-extended only when it is the most significant nibble of
// its operand; every other nibble is zero-extended.
// Assumes: N_SUB = GRP*GRP, and each operand vector carries N_SUB nibbles.
module simd_submul_array
    import simd_mac_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int N_SUB = 16,
    parameter int GRP   = 4,
    parameter int PP_W  = 2 * (NIB_W + 1)
) (
    input  mode_e                   mode,
    input  logic [N_SUB*NIB_W-1:0]  a_vec,
    input  logic [N_SUB*NIB_W-1:0]  b_vec,
    output logic [N_SUB*PP_W-1:0]   pp_flat
);

    for (genvar k = 0; k < N_SUB; k++) begin : g_sub
        localparam int S = k % GRP;
        localparam int L = k / GRP;

        logic [NIB_W-1:0]        a_nib, b_nib;
        logic                    a_sgn, b_sgn;
        logic signed [NIB_W:0]   a_ext, b_ext;
        logic signed [PP_W-1:0]  prod;

        // Pick this sub-multiplier's nibbles and their signedness for the mode.
        always_comb begin
            unique case (mode)
                MODE_4X4: begin
                    a_nib = a_vec[NIB_W*k +: NIB_W];
                    b_nib = b_vec[NIB_W*k +: NIB_W];
                    a_sgn = 1'b1;
                    b_sgn = 1'b1;
                end
                MODE_8X8: begin
                    a_nib = a_vec[2*NIB_W*L + NIB_W*(S%2) +: NIB_W];
                    b_nib = b_vec[2*NIB_W*L + NIB_W*(S/2) +: NIB_W];
                    a_sgn = (S % 2) == 1;
                    b_sgn = (S / 2) == 1;
                end
                MODE_16X16: begin
                    a_nib = a_vec[NIB_W*S +: NIB_W];
                    b_nib = b_vec[NIB_W*L +: NIB_W];
                    a_sgn = S == GRP - 1;
                    b_sgn = L == GRP - 1;
                end
                default: begin
                    a_nib = a_vec[GRP*NIB_W*L + NIB_W*S +: NIB_W];
                    b_nib = b_vec[NIB_W*L +: NIB_W];
                    a_sgn = S == GRP - 1;
                    b_sgn = 1'b1;
                end
            endcase
        end

        // Extend each nibble by one bit and form the signed sub-product.
        always_comb begin
            a_ext = {a_sgn & a_nib[NIB_W-1], a_nib};
            b_ext = {b_sgn & b_nib[NIB_W-1], b_nib};
            prod  = a_ext * b_ext;
        end

        assign pp_flat[PP_W*k +: PP_W] = prod;
    end

endmodule

// File: rtl/simd_lane_reducer.sv
// Module: simd_lane_reducer
// Combines sub-products into lane products.
// Each group of GRP sub-products is shifted and summed into one group sum.
// In 8x8 mode the nibble weights follow the 2x2 pattern; in the other modes
// they step by one nibble.
// The group sums are then weighted again and added into a full-width product
// for 16x16.
// Assumes: the sub-product ordering produced by simd_submul_array.
module simd_lane_reducer
    import simd_mac_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int N_SUB  = 16,
    parameter int GRP    = 4,
    parameter int PP_W   = 2 * (NIB_W + 1),
    parameter int GRP_W  = 5 * NIB_W + 4,
    parameter int FULL_W = 8 * NIB_W + 4
) (
    input  mode_e                       mode,
    input  logic [N_SUB*PP_W-1:0]       pp_flat,
    output logic [GRP*GRP_W-1:0]        grp_flat,
    output logic signed [FULL_W-1:0]    full
);

    logic signed [GRP_W-1:0] grp_sum [GRP];

    for (genvar l = 0; l < GRP; l++) begin : g_grp
        // Shift each sub-product to its nibble weight and sum the group.
        always_comb begin
            grp_sum[l] = '0;
            for (int s = 0; s < GRP; s++) begin
                logic signed [GRP_W-1:0] term;
                int                      sh;
                if (mode == MODE_8X8) sh = NIB_W * ((s % 2) + (s / 2));
                else                  sh = NIB_W * s;
                term = GRP_W'($signed(pp_flat[PP_W*(GRP*l + s) +: PP_W]));
                grp_sum[l] = grp_sum[l] + (term <<< sh);
            end
        end
        assign grp_flat[GRP_W*l +: GRP_W] = grp_sum[l];
    end

    // Weight the group sums by the second operand's nibble position.
    always_comb begin
        full = '0;
        for (int l = 0; l < GRP; l++) begin
            full = full + (FULL_W'(grp_sum[l]) <<< (NIB_W * l));
        end
    end

endmodule

// File: rtl/simd_acc_bank.sv
// Module: simd_acc_bank
// Per-lane accumulators in one flat register.
// In 4x4 mode the lanes are packed at their own width.
// In the other modes each lane owns a slot of SLOT_W bits; its sum wraps at
// the lane width and is stored sign-extended.
// Clear takes priority over accumulation.
// Assumes: the mode only changes on an edge where clear is high.
module simd_acc_bank
    import simd_mac_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int N_SUB  = 16,
    parameter int GRP    = 4,
    parameter int PP_W   = 2 * (NIB_W + 1),
    parameter int GRP_W  = 5 * NIB_W + 4,
    parameter int FULL_W = 8 * NIB_W + 4,
    parameter int ACC_W  = N_SUB * (2 * NIB_W + 4)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  mode_e                    mode,
    input  logic                     vld,
    input  logic                     clear,
    input  logic [N_SUB*PP_W-1:0]    pp_flat,
    input  logic [GRP*GRP_W-1:0]     grp_flat,
    input  logic signed [FULL_W-1:0] full,
    output logic [ACC_W-1:0]         acc_q
);

    localparam int W4     = 2 * NIB_W + 4;
    localparam int W8     = 4 * NIB_W + 4;
    localparam int W16    = FULL_W;
    localparam int W164   = GRP_W;
    localparam int SLOT_W = ACC_W / GRP;

    logic [ACC_W-1:0] acc_d;

    // Next accumulator state: clear, accumulate for the mode, or hold.
    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (vld) begin
            unique case (mode)
                MODE_4X4: begin
                    for (int k = 0; k < N_SUB; k++) begin
                        acc_d[W4*k +: W4] = acc_q[W4*k +: W4]
                            + W4'($signed(pp_flat[PP_W*k +: PP_W]));
                    end
                end
                MODE_8X8: begin
                    for (int l = 0; l < GRP; l++) begin
                        acc_d[SLOT_W*l +: SLOT_W] = SLOT_W'($signed(W8'(
                            acc_q[SLOT_W*l +: W8] + grp_flat[GRP_W*l +: W8])));
                    end
                end
                MODE_16X16: begin
                    acc_d = '0;
                    acc_d[0 +: SLOT_W] = SLOT_W'($signed(W16'(
                        acc_q[0 +: W16] + full)));
                end
                default: begin
                    for (int l = 0; l < GRP; l++) begin
                        acc_d[SLOT_W*l +: SLOT_W] = SLOT_W'($signed(W164'(
                            acc_q[SLOT_W*l +: W164] + grp_flat[GRP_W*l +: W164])));
                    end
                end
            endcase
        end
    end

    // Accumulator register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R8: a clear leaves every lane at zero on the next edge.
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

    // R7: with no product in flight and no clear, the bank holds its value.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !clear) |=> $stable(acc_q));

    // R3: in 16x16 mode nothing above the single slot is ever set.
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_16X16) |-> (acc_q[ACC_W-1:SLOT_W] == '0));

    // R2: an 8x8 lane slot always holds a sign-extended 20-bit value.
    a_r2_slot_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_8X8) |->
            ((acc_q[SLOT_W-1:W8-1] == '0) || (&acc_q[SLOT_W-1:W8-1])));

endmodule

// File: rtl/simd_mac_pe.sv
// Module: simd_mac_pe (top)
// Precision-configurable SIMD multiply-accumulate element.
// Stage 1 forms the sub-products and registers them.
// Stage 2 reduces the registered sub-products to lane products and
// accumulates them.
// The mode is latched on clear, and both stages use the latched value.
// Assumes: callers clear after reset or whenever they need a different mode.
module simd_mac_pe
    import simd_mac_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int GRP   = 4,
    parameter int N_SUB = GRP * GRP,
    parameter int OP_W  = N_SUB * NIB_W,
    parameter int ACC_W = N_SUB * (2 * NIB_W + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              valid,
    input  logic              clear,
    input  logic [OP_W-1:0]   a_vec,
    input  logic [OP_W-1:0]   b_vec,
    output logic [ACC_W-1:0]  acc_out
);

    localparam int PP_W   = 2 * (NIB_W + 1);
    localparam int GRP_W  = 5 * NIB_W + 4;
    localparam int FULL_W = 8 * NIB_W + 4;

    mode_e                    mode_q;
    logic [N_SUB*PP_W-1:0]    pp_d, pp_q;
    logic                     vld_q;
    logic [GRP*GRP_W-1:0]     grp_flat;
    logic signed [FULL_W-1:0] full;

    // Latch the mode only when the accumulators are cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= MODE_4X4;
        else if (clear) mode_q <= mode_e'(mode);
    end

    simd_submul_array #(
        .NIB_W(NIB_W), .N_SUB(N_SUB), .GRP(GRP), .PP_W(PP_W)
    ) submul_i (
        .mode(mode_q), .a_vec(a_vec), .b_vec(b_vec), .pp_flat(pp_d)
    );

    // Pipeline register between the products and the accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            pp_q  <= '0;
        end else begin
            vld_q <= valid & ~clear;
            if (valid) pp_q <= pp_d;
        end
    end

    simd_lane_reducer #(
        .NIB_W(NIB_W), .N_SUB(N_SUB), .GRP(GRP), .PP_W(PP_W),
        .GRP_W(GRP_W), .FULL_W(FULL_W)
    ) reducer_i (
        .mode(mode_q), .pp_flat(pp_q), .grp_flat(grp_flat), .full(full)
    );

    simd_acc_bank #(
        .NIB_W(NIB_W), .N_SUB(N_SUB), .GRP(GRP), .PP_W(PP_W),
        .GRP_W(GRP_W), .FULL_W(FULL_W), .ACC_W(ACC_W)
    ) acc_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .vld(vld_q), .clear(clear),
        .pp_flat(pp_q), .grp_flat(grp_flat), .full(full), .acc_q(acc_out)
    );

    // R9: the latched mode moves only on an edge with clear high.
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(mode_q));

    // R6: a valid vector without clear always enters the pipeline stage.
    a_r6_stage_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear) |=> vld_q);

endmodule

// File: tb/simd_mac_pe_tb.sv
module simd_mac_pe_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic         valid;
    logic         clear;
    logic [63:0]  a_vec, b_vec;
    logic [191:0] acc_out;

    int           n_vec  = 0;
    int           n_fail = 0;
    longint       elane [16];
    logic [1:0]   mb;
    logic [63:0]  seed = 64'h1234_5678_9abc_def1;

    always #4 clk = ~clk;

    simd_mac_pe dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .valid(valid), .clear(clear),
        .a_vec(a_vec), .b_vec(b_vec), .acc_out(acc_out)
    );

    function automatic longint sx(logic [63:0] v, int w);
        longint t;
        t = $signed(v << (64 - w));
        return t >>> (64 - w);
    endfunction

    function automatic logic [63:0] rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    function automatic logic [191:0] expected();
        logic [191:0] v = '0;
        logic [63:0]  t;
        case (mb)
            2'b00:   for (int k = 0; k < 16; k++) begin t = elane[k]; v[12*k +: 12] = t[11:0]; end
            2'b10:   begin t = elane[0]; v[47:0] = t[47:0]; end
            default: for (int l = 0; l < 4; l++) begin t = elane[l]; v[48*l +: 48] = t[47:0]; end
        endcase
        return v;
    endfunction

    task automatic model_add(logic [63:0] a, logic [63:0] b);
        case (mb)
            2'b00: for (int k = 0; k < 16; k++)
                elane[k] = sx(elane[k] + sx(a >> (4*k), 4) * sx(b >> (4*k), 4), 12);
            2'b01: for (int l = 0; l < 4; l++)
                elane[l] = sx(elane[l] + sx(a >> (8*l), 8) * sx(b >> (8*l), 8), 20);
            2'b10: elane[0] = sx(elane[0] + sx(a, 16) * sx(b, 16), 36);
            default: for (int l = 0; l < 4; l++)
                elane[l] = sx(elane[l] + sx(a >> (16*l), 16) * sx(b >> (4*l), 4), 24);
        endcase
    endtask

    task automatic check(string req, logic [191:0] exp);
        n_vec++;
        if (acc_out !== exp) begin
            n_fail++;
            $display("FAIL %s: acc_out=%h expected=%h", req, acc_out, exp);
        end
    endtask

    // One vector: drive, wait through the pipeline and accumulate edges, compare.
    task automatic apply(logic [63:0] a, logic [63:0] b, string req);
        @(negedge clk); a_vec = a; b_vec = b; valid = 1'b1;
        @(negedge clk); valid = 1'b0; a_vec = rnd(); b_vec = rnd();
        @(negedge clk);
        model_add(a, b);
        check(req, expected());
    endtask

    // Clear with a new mode; optionally offer a vector in the same cycle (R8).
    task automatic do_clear(logic [1:0] m, logic with_valid);
        @(negedge clk); clear = 1'b1; mode = m; valid = with_valid;
        a_vec = 64'h7777_7777_7777_7777; b_vec = 64'h7777_7777_7777_7777;
        @(negedge clk); clear = 1'b0; valid = 1'b0;
        mb = m;
        for (int i = 0; i < 16; i++) elane[i] = 0;
        check("R8 clear zeroes", '0);
        @(negedge clk);
        check("R8 same-cycle vector dropped", '0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stimulus
        logic [191:0] snap;
        logic [63:0]  a, b;
        rst_n = 1'b0; mode = 2'b11; valid = 1'b0; clear = 1'b0;
        a_vec = '0; b_vec = '0; mb = 2'b00;
        for (int i = 0; i < 16; i++) elane[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset zero", '0);

        // R1/R5/R11: default 4x4 mode, every signed nibble pair across lanes.
        for (int v = 0; v < 16; v++) begin
            a = '0; b = '0;
            for (int k = 0; k < 16; k++) begin
                a[4*k +: 4] = 4'(k);
                b[4*k +: 4] = 4'(v);
            end
            apply(a, b, "R1 4x4 exhaustive");
        end

        // R6: latency of one pipeline stage, back-to-back vectors.
        snap = expected();
        a = rnd(); b = rnd();
        @(negedge clk); a_vec = a; b_vec = b; valid = 1'b1;
        @(negedge clk);
        check("R6 not visible after one edge", snap);
        model_add(a, b);
        a = rnd(); b = rnd(); a_vec = a; b_vec = b;
        @(negedge clk); valid = 1'b0;
        check("R6 first visible after two edges", expected());
        model_add(a, b);
        @(negedge clk);
        check("R6 back-to-back accumulated", expected());

        // R7: idle cycles with changing operands.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); a_vec = rnd(); b_vec = rnd();
        end
        @(negedge clk);
        check("R7 valid low holds", expected());

        // R2/R5: 8x8 mode with extremes and a sweep.
        do_clear(2'b01, 1'b1);
        apply(64'h8080_8080, 64'h7F80_7F80, "R2 8x8 extremes");
        for (int v = 0; v < 63; v++) apply(rnd(), rnd(), "R2 8x8 sweep");

        // R8: a vector in the pipeline register is lost to a clear.
        @(negedge clk); a_vec = rnd(); b_vec = rnd(); valid = 1'b1;
        @(negedge clk); valid = 1'b0; clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        for (int i = 0; i < 16; i++) elane[i] = 0;
        check("R8 in-flight dropped", '0);
        @(negedge clk);
        check("R8 in-flight stays dropped", '0);

        // R3: 16x16 mode.
        do_clear(2'b10, 1'b0);
        apply(64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF, "R3 16x16 extreme");
        for (int v = 0; v < 24; v++) apply(rnd(), rnd(), "R3 16x16 sweep");

        // R10: 36-bit wrap with the largest product.
        do_clear(2'b10, 1'b0);
        for (int v = 0; v < 40; v++)
            apply(64'hFFFF_FFFF_FFFF_8000, 64'h0000_0000_0000_8000, "R10 16x16 wrap");

        // R4: 16x4 mode.
        do_clear(2'b11, 1'b0);
        apply(64'h8000_7FFF_8000_FFFF, 64'h0000_0000_0000_8787, "R4 16x4 extremes");
        for (int v = 0; v < 63; v++) apply(rnd(), rnd(), "R4 16x4 sweep");

        // R9: a mode change without clear is ignored.
        mode = 2'b00;
        for (int v = 0; v < 8; v++) apply(rnd(), rnd(), "R9 mode ignored without clear");

        // R10: 12-bit wrap in 4x4 mode.
        do_clear(2'b00, 1'b1);
        for (int v = 0; v < 40; v++)
            apply(64'h8888_8888_8888_8888, 64'h8888_8888_8888_8888, "R10 4x4 wrap");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule